// File: doc/BRIEF.md
# Voltage Sag and Surge Monitor

The monitor watches a voltage RMS value that an upstream stage refreshes once per half line cycle, announcing each new value with a one-cycle strobe. Each fresh reading is compared against a low threshold and a high threshold. The block counts how many readings in a row fall below the low threshold, and separately how many in a row rise above the high threshold. When either run reaches its programmed length, a sticky event flag is set and an interrupt is raised for that event if it is enabled.

While a run is in progress, the block keeps the extreme value seen in it: the lowest reading during a sag and the highest during a surge. Each tracker restarts with the first reading of a new run, so an old event never colours a later one. Software clears the flags by pulsing the matching bit of the clear input. Working out the RMS value itself happens upstream and is not part of this block.

Top module: `sag_surge_monitor`

## Requirements
- R1: A reading is taken only on a cycle with `rms_valid` high. It counts as low when `rms_value < dip_level` and as high when `rms_value > swell_level`. A value equal to a threshold is in range. Without the strobe, no flag, tracker or run count changes.
- R2: `flags[0]` (sag) is set at the clock edge that takes the low reading which brings the consecutive low count to `dip_limit`, or to any later count in the same run. A limit of 0 acts as 1. The flag is visible in the cycle after the strobe.
- R3: `flags[1]` (surge) follows the same rule for high readings against `swell_limit`, again with a limit of 0 acting as 1.
- R4: A reading that is not low resets the low run count to zero, and a reading that is not high resets the high run count to zero. Run counts saturate at 2^CNT_W-1 and never wrap.
- R5: `dip_min` loads the first low reading of a run and afterwards takes the smaller of itself and each further low reading. It holds its value between runs.
- R6: `swell_max` loads the first high reading of a run and afterwards takes the larger of itself and each further high reading. It holds its value between runs.
- R7: The flags are sticky. A one on `flag_clear[i]` for a cycle clears `flags[i]` and leaves the other bit alone. If a set and a clear of the same bit fall on the same edge, the set wins.
- R8: `irq` is high exactly when some `flags[i]` is set with `irq_enable[i]` high. It follows the flags and the enables with no added register.
- R9: After reset, `flags`, `dip_min`, `swell_max`, `irq` and both run counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rms_valid | input | 1 | Strobe marking a new half-cycle RMS reading |
| rms_value | input | RMS_W | Half-cycle RMS reading |
| dip_level | input | RMS_W | Sag threshold; readings strictly below it count |
| swell_level | input | RMS_W | Surge threshold; readings strictly above it count |
| dip_limit | input | CNT_W | Consecutive low readings needed for a sag event |
| swell_limit | input | CNT_W | Consecutive high readings needed for a surge event |
| irq_enable | input | 2 | Per-flag interrupt enable (bit 0 sag, bit 1 surge) |
| flag_clear | input | 2 | Write-one-to-clear pulse per flag |
| flags | output | 2 | Sticky event flags (bit 0 sag, bit 1 surge) |
| dip_min | output | RMS_W | Lowest reading of the current or last sag run |
| swell_max | output | RMS_W | Highest reading of the current or last surge run |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep drives every run length from 0 to 7 against every limit from 0 to 7 for both sags and surges, with varied reading values inside each run. This separates off-by-one errors in the threshold count, shows the limit-0 case behaving like 1, and exposes a wrong minimum or maximum. Broken runs, where one in-range reading splits two short runs, show whether the count resets rather than accumulating. Two back-to-back runs with different ranges show whether the extreme trackers reload. Readings placed exactly on each threshold, strobe-less changes of the value, a run long enough to saturate the counter, and clears that land on the same edge as a set or on one flag only cover the remaining boundaries.

// File: rtl/sag_surge_monitor.sv
module sag_surge_monitor #(
  parameter int RMS_W = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rms_valid,
  input  logic [RMS_W-1:0] rms_value,
  input  logic [RMS_W-1:0] dip_level,
  input  logic [RMS_W-1:0] swell_level,
  input  logic [CNT_W-1:0] dip_limit,
  input  logic [CNT_W-1:0] swell_limit,
  input  logic [1:0]       irq_enable,
  input  logic [1:0]       flag_clear,
  output logic [1:0]       flags,
  output logic [RMS_W-1:0] dip_min,
  output logic [RMS_W-1:0] swell_max,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] low_run, high_run;

  wire is_low  = rms_valid && (rms_value < dip_level);
  wire is_high = rms_valid && (rms_value > swell_level);

  wire [CNT_W-1:0] low_next  = (low_run  == CNT_MAX) ? low_run  : low_run  + CNT_ONE;
  wire [CNT_W-1:0] high_next = (high_run == CNT_MAX) ? high_run : high_run + CNT_ONE;

  wire [CNT_W-1:0] low_need  = (dip_limit   == '0) ? CNT_ONE : dip_limit;
  wire [CNT_W-1:0] high_need = (swell_limit == '0) ? CNT_ONE : swell_limit;

  wire low_hit  = is_low  && (low_next  >= low_need);
  wire high_hit = is_high && (high_next >= high_need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else if (rms_valid) begin
      low_run  <= is_low  ? low_next  : '0;
      high_run <= is_high ? high_next : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dip_min   <= '0;
      swell_max <= '0;
    end else begin
      if (is_low && (low_run == '0 || rms_value < dip_min))
        dip_min <= rms_value;
      if (is_high && (high_run == '0 || rms_value > swell_max))
        swell_max <= rms_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= {high_hit, low_hit} | (flags & ~flag_clear);
  end

  assign irq = |(flags & irq_enable);
endmodule

// File: rtl/sag_surge_monitor_chk.sv
module sag_surge_monitor_chk #(
  parameter int RMS_W = 24,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rms_valid,
  input logic [RMS_W-1:0] rms_value,
  input logic [RMS_W-1:0] dip_level,
  input logic [RMS_W-1:0] swell_level,
  input logic [1:0]       flag_clear,
  input logic [1:0]       flags,
  input logic [RMS_W-1:0] dip_min,
  input logic [RMS_W-1:0] swell_max,
  input logic             irq
);
  assert_dip_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(rms_valid) && ($past(rms_value) < $past(dip_level)));

  assert_swell_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(rms_valid) && ($past(rms_value) > $past(swell_level)));

  assert_hold_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rms_valid |=> $stable(dip_min) && $stable(swell_max));

  assert_dip_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rms_valid && rms_value < dip_level) |=> dip_min <= $past(rms_value));

  assert_swell_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rms_valid && rms_value > swell_level) |=> swell_max >= $past(rms_value));

  assert_dip_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clear[0]) |=> flags[0]);

  assert_swell_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !flag_clear[1]) |=> flags[1]);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 2'b00) |-> !irq);
endmodule

bind sag_surge_monitor sag_surge_monitor_chk #(.RMS_W(RMS_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .rms_valid(rms_valid), .rms_value(rms_value),
  .dip_level(dip_level), .swell_level(swell_level), .flag_clear(flag_clear),
  .flags(flags), .dip_min(dip_min), .swell_max(swell_max), .irq(irq)
);

// File: tb/sag_surge_monitor_test.sv
module sag_surge_monitor_test;
  localparam int RW = 8;
  localparam int CW = 3;

  logic          clk = 0, rst_n = 0, rms_valid = 0;
  logic [RW-1:0] rms_value = 100, dip_level = 40, swell_level = 180;
  logic [CW-1:0] dip_limit = 1, swell_limit = 1;
  logic [1:0]    irq_enable = 2'b11, flag_clear = 2'b00;
  logic [1:0]    flags;
  logic [RW-1:0] dip_min, swell_max;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  sag_surge_monitor #(.RMS_W(RW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .rms_valid(rms_valid), .rms_value(rms_value),
    .dip_level(dip_level), .swell_level(swell_level), .dip_limit(dip_limit),
    .swell_limit(swell_limit), .irq_enable(irq_enable), .flag_clear(flag_clear),
    .flags(flags), .dip_min(dip_min), .swell_max(swell_max), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reading(input int v);
    @(negedge clk); rms_valid = 1; rms_value = RW'(v);
    @(negedge clk); rms_valid = 0;
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk); flag_clear = m;
    @(negedge clk); flag_clear = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 flags", flags, 0);
    chk("R9 dip_min", dip_min, 0);
    chk("R9 swell_max", swell_max, 0);
    chk("R9 irq", irq, 0);
    rst_n = 1;

    for (int lim = 0; lim < 8; lim++) begin
      for (int n = 0; n < 8; n++) begin
        int need, mn, mx;
        need = (lim == 0) ? 1 : lim;
        dip_limit = CW'(lim); swell_limit = CW'(lim);
        reading(100); clear(2'b11);
        mn = 255;
        for (int k = 0; k < n; k++) begin
          int v = 20 + (k * 7) % 13;
          if (v < mn) mn = v;
          reading(v);
        end
        chk("R2 sag flag", flags[0], int'(n >= need));
        chk("R8 irq sag", irq, int'(n >= need));
        if (n > 0) chk("R5 dip_min", dip_min, mn);
        reading(100); clear(2'b11);
        mx = 0;
        for (int k = 0; k < n; k++) begin
          int v = 200 + (k * 5) % 11;
          if (v > mx) mx = v;
          reading(v);
        end
        chk("R3 surge flag", flags[1], int'(n >= need));
        if (n > 0) chk("R6 swell_max", swell_max, mx);
      end
    end

    dip_limit = 4; swell_limit = 4;
    reading(100); clear(2'b11);
    for (int k = 0; k < 3; k++) reading(10);
    reading(100);
    for (int k = 0; k < 3; k++) reading(10);
    chk("R4 broken sag run", flags[0], 0);
    reading(10);
    chk("R4 sag after four in a row", flags[0], 1);
    reading(100);
    for (int k = 0; k < 3; k++) reading(220);
    reading(180);
    for (int k = 0; k < 3; k++) reading(220);
    chk("R4 broken surge run", flags[1], 0);

    dip_limit = 7;
    reading(100); clear(2'b11);
    for (int k = 0; k < 9; k++) reading(15);
    clear(2'b01);
    chk("R7 clear sag", flags[0], 0);
    reading(15);
    chk("R4 saturated count keeps event", flags[0], 1);

    dip_limit = 1; swell_limit = 1;
    reading(100); clear(2'b11);
    reading(5); reading(6); reading(100); reading(30); reading(25);
    chk("R5 dip_min reload", dip_min, 25);
    reading(250); reading(255); reading(100); reading(190); reading(185);
    chk("R6 swell_max reload", swell_max, 190);

    reading(100); clear(2'b11);
    reading(40);
    chk("R1 equal to dip level", flags[0], 0);
    reading(39);
    chk("R1 just below dip level", flags[0], 1);
    reading(180);
    chk("R1 equal to swell level", flags[1], 0);
    reading(181);
    chk("R1 just above swell level", flags[1], 1);

    clear(2'b11);
    @(negedge clk); rms_value = 1;
    repeat (4) @(negedge clk);
    rms_value = 250;
    repeat (4) @(negedge clk);
    chk("R1 no strobe flags", flags, 0);
    chk("R1 no strobe dip_min", dip_min, 39);
    chk("R1 no strobe swell_max", swell_max, 181);

    reading(10); reading(250);
    chk("R7 both set", flags, 3);
    clear(2'b01);
    chk("R7 selective clear", flags, 2);
    @(negedge clk); rms_valid = 1; rms_value = 10; flag_clear = 2'b01;
    @(negedge clk); rms_valid = 0; flag_clear = 0;
    chk("R7 set wins over clear", flags[0], 1);

    clear(2'b10);
    irq_enable = 2'b10; #1;
    chk("R8 masked irq", irq, 0);
    irq_enable = 2'b01; #1;
    chk("R8 enabled irq", irq, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule